// File: doc/BRIEF.md
# Protection Fault Delay Controller

This block sits between the comparators of a multi-cell battery protector and its two fault pins. One pin gates charging and the other gates discharging. Each fault flag arrives already compared, with hysteresis applied. The block qualifies each flag through its own delay timer. Only when a flag has been held for the whole programmed delay does it assert the outputs that the fault maps to. The timers advance on a slow timebase tick, one tick per millisecond in the intended use.

Overvoltage goes to the charge pin only and undervoltage to the discharge pin only. A broken sense connection and an over-temperature reading both go to the two pins. A failing oscillator also goes to both pins, and it acts at once with no delay. A test mode swaps every delay for one short common delay so that production tests run quickly. A latch option holds any asserted pin until reset. The pin polarity is chosen between a push-pull active-high style and an open-drain active-low style. A mode output reports FAULT while either pin is asserted and NORMAL otherwise.

Top module: `prot_delay_ctrl`

## Requirements
- R1: With a delayed fault held, its output asserts one clock after the L-th tick, and not before. L = BASE_TICKS << s, where s is the 3-bit delay select (0..4) and any select value 5..7 acts as 4. Overvoltage, undervoltage and over-temperature each have their own select.
- R2: If a delayed fault flag drops before its timer expires, that timer returns to zero, and a later assertion again needs the full L ticks.
- R3: Overvoltage asserts the charge output only. The discharge output stays inactive.
- R4: Undervoltage asserts the discharge output only. The charge output stays inactive.
- R5: Open-wire and over-temperature faults assert both outputs. The open-wire delay is fixed at BASE_TICKS << 4 ticks.
- R6: An oscillator fault asserts both outputs on the next clock edge, with no tick delay.
- R7: While test_mode_i is 1, every delayed fault uses CTM_TICKS ticks instead of its normal delay.
- R8: A change of test_mode_i restarts all running timers from zero.
- R9: With latch_en_i at 1, an asserted output stays asserted after its fault clears, until rst_ni is driven low.
- R10: With latch_en_i at 0, an output goes inactive on the clock edge after all the faults mapped to it have cleared.
- R11: With act_low_i at 0, each output drives (oe=1) with drv equal to its active state. With act_low_i at 1, drv is always 0 and oe=1 only while the output is active; otherwise the pin is released.
- R12: fault_mode_o is 1 (FAULT) exactly when either output is active, and 0 (NORMAL) otherwise.
- R13: After reset, both outputs are inactive and fault_mode_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one clock wide |
| ov_i | input | 1 | Overvoltage flag |
| uv_i | input | 1 | Undervoltage flag |
| ow_i | input | 1 | Open-wire flag |
| ot_i | input | 1 | Over-temperature flag |
| osc_bad_i | input | 1 | Oscillator fault flag |
| test_mode_i | input | 1 | Short-delay test mode request |
| latch_en_i | input | 1 | Hold asserted outputs until reset |
| act_low_i | input | 1 | 1 selects the open-drain active-low style |
| ov_dly_sel_i | input | 3 | Overvoltage delay select |
| uv_dly_sel_i | input | 3 | Undervoltage delay select |
| ot_dly_sel_i | input | 3 | Over-temperature delay select |
| chg_drv_o | output | 1 | Charge pin drive level |
| chg_oe_o | output | 1 | Charge pin drive enable |
| dis_drv_o | output | 1 | Discharge pin drive level |
| dis_oe_o | output | 1 | Discharge pin drive enable |
| fault_mode_o | output | 1 | 1 = FAULT, 0 = NORMAL |

## Verification
A delayed fault's timer counts on the clock edge where a tick is seen. Once the count reaches its limit, the output register sets on the following edge. The bench therefore drives each tick for exactly one clock period between falling edges, and it samples at the falling edge after the last tick period. The count just short of the limit is sampled at the same point, one tick earlier. An oscillator fault, a cleared fault without latching and a test-mode change each take effect on the single next rising edge, so those checks sample at the following falling edge.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int N_TMR  = 4;
  localparam int IDX_OV = 0;
  localparam int IDX_UV = 1;
  localparam int IDX_OW = 2;
  localparam int IDX_OT = 3;
  localparam int SEL_W  = 3;
  localparam int SEL_MAX = 4;

  // routing of timer outputs onto the two pins
  localparam logic [N_TMR-1:0] CHG_MAP = 4'b1101;
  localparam logic [N_TMR-1:0] DIS_MAP = 4'b1110;

  typedef enum logic {MODE_NORMAL = 1'b0, MODE_FAULT = 1'b1} mode_e;
endpackage

// File: rtl/pdc_limit_dec.sv
module pdc_limit_dec
  import pdc_pkg::*;
#(
  parameter int BASE_TICKS = 250,
  parameter int CTM_TICKS  = 100,
  parameter int CW         = 12,
  parameter bit FIXED_MAX  = 1'b0
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             test_i,
  output logic [CW-1:0]    limit_o
);
  localparam logic [CW-1:0] BASE_L = CW'(BASE_TICKS);
  localparam logic [CW-1:0] CTM_L  = CW'(CTM_TICKS);

  logic [SEL_W-1:0] shift;

  generate
    if (FIXED_MAX) begin : g_fixed
      assign shift = SEL_W'(SEL_MAX);
    end else begin : g_sel
      assign shift = (sel_i > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel_i;
    end
  endgenerate

  assign limit_o = test_i ? CTM_L : (BASE_L << shift);
endmodule

// File: rtl/pdc_fault_timer.sv
module pdc_fault_timer #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          flag_i,
  input  logic          restart_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;
  logic          at_limit;

  assign at_limit = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!flag_i || restart_i) begin
      cnt_q <= '0;
    end else if (tick_i && !at_limit) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // flag gates expiry directly so recovery is seen without waiting on the count
  assign expired_o = flag_i && !restart_i && at_limit;
endmodule

// File: rtl/pdc_out_stage.sv
module pdc_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_chg_i,
  input  logic req_dis_i,
  input  logic latch_en_i,
  input  logic act_low_i,
  output logic chg_drv_o,
  output logic chg_oe_o,
  output logic dis_drv_o,
  output logic dis_oe_o,
  output logic fault_mode_o
);
  import pdc_pkg::*;

  logic  chg_q, dis_q;
  mode_e mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_q <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      chg_q <= req_chg_i | (latch_en_i & chg_q);
      dis_q <= req_dis_i | (latch_en_i & dis_q);
    end
  end

  assign mode         = (chg_q | dis_q) ? MODE_FAULT : MODE_NORMAL;
  assign fault_mode_o = (mode == MODE_FAULT);

  // active-high: always driven; active-low: drive 0 only while active
  assign chg_drv_o = chg_q & ~act_low_i;
  assign chg_oe_o  = chg_q | ~act_low_i;
  assign dis_drv_o = dis_q & ~act_low_i;
  assign dis_oe_o  = dis_q | ~act_low_i;
endmodule

// File: rtl/prot_delay_ctrl.sv
module prot_delay_ctrl
  import pdc_pkg::*;
#(
  parameter int BASE_TICKS = 250,
  parameter int CTM_TICKS  = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       ov_i,
  input  logic       uv_i,
  input  logic       ow_i,
  input  logic       ot_i,
  input  logic       osc_bad_i,
  input  logic       test_mode_i,
  input  logic       latch_en_i,
  input  logic       act_low_i,
  input  logic [2:0] ov_dly_sel_i,
  input  logic [2:0] uv_dly_sel_i,
  input  logic [2:0] ot_dly_sel_i,
  output logic       chg_drv_o,
  output logic       chg_oe_o,
  output logic       dis_drv_o,
  output logic       dis_oe_o,
  output logic       fault_mode_o
);
  localparam int MAX_TICKS = BASE_TICKS << SEL_MAX;
  localparam int CW        = $clog2(MAX_TICKS + 1);

  logic [N_TMR-1:0] flags;
  logic [N_TMR-1:0] expired;
  logic [SEL_W-1:0] sels [N_TMR];
  logic             tm_q;
  logic             restart;
  logic             req_chg, req_dis;

  assign flags[IDX_OV] = ov_i;
  assign flags[IDX_UV] = uv_i;
  assign flags[IDX_OW] = ow_i;
  assign flags[IDX_OT] = ot_i;
  assign sels[IDX_OV]  = ov_dly_sel_i;
  assign sels[IDX_UV]  = uv_dly_sel_i;
  assign sels[IDX_OW]  = SEL_W'(SEL_MAX);
  assign sels[IDX_OT]  = ot_dly_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tm_q <= 1'b0;
    else         tm_q <= test_mode_i;
  end

  assign restart = tm_q ^ test_mode_i;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic [CW-1:0] limit;

    pdc_limit_dec #(
      .BASE_TICKS(BASE_TICKS),
      .CTM_TICKS (CTM_TICKS),
      .CW        (CW),
      .FIXED_MAX (i == IDX_OW)
    ) u_dec (
      .sel_i  (sels[i]),
      .test_i (tm_q),
      .limit_o(limit)
    );

    pdc_fault_timer #(.CW(CW)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .flag_i   (flags[i]),
      .restart_i(restart),
      .limit_i  (limit),
      .expired_o(expired[i])
    );
  end

  // oscillator fault bypasses the timers
  assign req_chg = |(expired & CHG_MAP) | osc_bad_i;
  assign req_dis = |(expired & DIS_MAP) | osc_bad_i;

  pdc_out_stage u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_chg_i   (req_chg),
    .req_dis_i   (req_dis),
    .latch_en_i  (latch_en_i),
    .act_low_i   (act_low_i),
    .chg_drv_o   (chg_drv_o),
    .chg_oe_o    (chg_oe_o),
    .dis_drv_o   (dis_drv_o),
    .dis_oe_o    (dis_oe_o),
    .fault_mode_o(fault_mode_o)
  );
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ov_i,
  input logic       uv_i,
  input logic       ow_i,
  input logic       ot_i,
  input logic       osc_bad_i,
  input logic       latch_en_i,
  input logic       act_low_i,
  input logic       chg_drv_o,
  input logic       chg_oe_o,
  input logic       dis_drv_o,
  input logic       dis_oe_o,
  input logic       fault_mode_o
);
  logic chg_act, dis_act;
  assign chg_act = act_low_i ? chg_oe_o : chg_drv_o;
  assign dis_act = act_low_i ? dis_oe_o : dis_drv_o;

  // R3: charge pin rises only from a fault mapped to it
  a_r3_chg_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(chg_act) && $stable(act_low_i)) |-> $past(ov_i | ow_i | ot_i | osc_bad_i));

  // R4: discharge pin rises only from a fault mapped to it
  a_r4_dis_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dis_act) && $stable(act_low_i)) |-> $past(uv_i | ow_i | ot_i | osc_bad_i));

  a_r6_osc_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_bad_i |=> (chg_act && dis_act));

  a_r9_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && chg_act && dis_act) |=> (!latch_en_i || (chg_act && dis_act))
      || !$stable(act_low_i));

  a_r11_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_low_i ? (!chg_drv_o && !dis_drv_o) : (chg_oe_o && dis_oe_o));

  a_r12_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_mode_o == (chg_act || dis_act));
endmodule

bind prot_delay_ctrl pdc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ov_i        (ov_i),
  .uv_i        (uv_i),
  .ow_i        (ow_i),
  .ot_i        (ot_i),
  .osc_bad_i   (osc_bad_i),
  .latch_en_i  (latch_en_i),
  .act_low_i   (act_low_i),
  .chg_drv_o   (chg_drv_o),
  .chg_oe_o    (chg_oe_o),
  .dis_drv_o   (dis_drv_o),
  .dis_oe_o    (dis_oe_o),
  .fault_mode_o(fault_mode_o)
);

// File: tb/tb_prot_delay_ctrl.sv
module tb_prot_delay_ctrl;
  localparam int BASE = 4;
  localparam int CTM  = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       ov_i = 1'b0, uv_i = 1'b0, ow_i = 1'b0, ot_i = 1'b0, osc_bad_i = 1'b0;
  logic       test_mode_i = 1'b0, latch_en_i = 1'b0, act_low_i = 1'b0;
  logic [2:0] ov_dly_sel_i = '0, uv_dly_sel_i = '0, ot_dly_sel_i = '0;
  logic       chg_drv_o, chg_oe_o, dis_drv_o, dis_oe_o, fault_mode_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  prot_delay_ctrl #(.BASE_TICKS(BASE), .CTM_TICKS(CTM)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .ov_i(ov_i), .uv_i(uv_i), .ow_i(ow_i), .ot_i(ot_i), .osc_bad_i(osc_bad_i),
    .test_mode_i(test_mode_i), .latch_en_i(latch_en_i), .act_low_i(act_low_i),
    .ov_dly_sel_i(ov_dly_sel_i), .uv_dly_sel_i(uv_dly_sel_i), .ot_dly_sel_i(ot_dly_sel_i),
    .chg_drv_o(chg_drv_o), .chg_oe_o(chg_oe_o), .dis_drv_o(dis_drv_o),
    .dis_oe_o(dis_oe_o), .fault_mode_o(fault_mode_o)
  );

  function automatic int dly(input int sel);
    return BASE << ((sel > 4) ? 4 : sel);
  endfunction

  task automatic expect_out(input bit ec, input bit ed, input string tag);
    bit ac, ad;
    ac = act_low_i ? chg_oe_o : chg_drv_o;
    ad = act_low_i ? dis_oe_o : dis_drv_o;
    n_vec++;
    if (ac !== ec || ad !== ed || fault_mode_o !== (ec | ed)) begin
      n_bad++;
      $display("FAIL %s: chg=%0b dis=%0b mode=%0b expected chg=%0b dis=%0b mode=%0b",
               tag, ac, ad, fault_mode_o, ec, ed, ec | ed);
    end
  endtask

  task automatic expect_pins(input bit cd, input bit co, input bit dd, input bit doe,
                             input string tag);
    n_vec++;
    if ({chg_drv_o, chg_oe_o, dis_drv_o, dis_oe_o} !== {cd, co, dd, doe}) begin
      n_bad++;
      $display("FAIL %s: pins=%b expected %b", tag,
               {chg_drv_o, chg_oe_o, dis_drv_o, dis_oe_o}, {cd, co, dd, doe});
    end
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  task automatic clear_flags();
    ov_i = 0; uv_i = 0; ow_i = 0; ot_i = 0; osc_bad_i = 0;
  endtask

  task automatic do_reset();
    clear_flags();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // which: 0 ov, 1 uv, 2 ow, 3 ot
  task automatic set_flag(input int which, input bit v);
    case (which)
      0: ov_i = v;
      1: uv_i = v;
      2: ow_i = v;
      default: ot_i = v;
    endcase
  endtask

  task automatic delay_case(input int which, input int len, input bit ec, input bit ed,
                            input string tag);
    set_flag(which, 1'b1);
    @(negedge clk_i);
    pulse(len - 1);
    expect_out(1'b0, 1'b0, {tag, " R1 before expiry"});
    pulse(1);
    expect_out(ec, ed, tag);
    set_flag(which, 1'b0);
    @(negedge clk_i);
    expect_out(1'b0, 1'b0, {tag, " R10 recovery"});
  endtask

  initial begin
    @(negedge clk_i);
    expect_out(1'b0, 1'b0, "R13 in reset");
    do_reset();
    expect_out(1'b0, 1'b0, "R13 after reset");
    expect_pins(1'b0, 1'b1, 1'b0, 1'b1, "R11 active-high idle");

    for (int s = 0; s < 8; s++) begin
      ov_dly_sel_i = 3'(s); uv_dly_sel_i = 3'(s); ot_dly_sel_i = 3'(s);
      delay_case(0, dly(s), 1'b1, 1'b0, "R3 ov map");
      delay_case(1, dly(s), 1'b0, 1'b1, "R4 uv map");
      delay_case(3, dly(s), 1'b1, 1'b1, "R5 ot map");
    end
    ov_dly_sel_i = 3'd0; uv_dly_sel_i = 3'd0; ot_dly_sel_i = 3'd0;
    delay_case(2, BASE << 4, 1'b1, 1'b1, "R5 ow fixed");

    // R2: early drop restarts the count
    ov_i = 1; @(negedge clk_i);
    pulse(BASE - 1);
    ov_i = 0; @(negedge clk_i);
    ov_i = 1; @(negedge clk_i);
    pulse(BASE - 1);
    expect_out(1'b0, 1'b0, "R2 restart after drop");
    pulse(1);
    expect_out(1'b1, 1'b0, "R2 full count after drop");
    clear_flags(); @(negedge clk_i);

    // R6: oscillator fault, no ticks
    osc_bad_i = 1; @(negedge clk_i);
    expect_out(1'b1, 1'b1, "R6 osc immediate");
    osc_bad_i = 0; @(negedge clk_i);
    expect_out(1'b0, 1'b0, "R6 osc recovers");

    // R7: test mode short delay
    test_mode_i = 1; @(negedge clk_i); @(negedge clk_i);
    ov_dly_sel_i = 3'd4; uv_dly_sel_i = 3'd3; ot_dly_sel_i = 3'd2;
    delay_case(0, CTM, 1'b1, 1'b0, "R7 ov test mode");
    delay_case(1, CTM, 1'b0, 1'b1, "R7 uv test mode");
    delay_case(2, CTM, 1'b1, 1'b1, "R7 ow test mode");
    delay_case(3, CTM, 1'b1, 1'b1, "R7 ot test mode");

    // R8: mode change restarts a running timer
    test_mode_i = 0; @(negedge clk_i);
    ov_dly_sel_i = 3'd2;
    ov_i = 1; @(negedge clk_i);
    pulse(10);
    test_mode_i = 1; @(negedge clk_i);
    expect_out(1'b0, 1'b0, "R8 entry restarts");
    pulse(CTM - 1);
    expect_out(1'b0, 1'b0, "R8 count from zero");
    pulse(1);
    expect_out(1'b1, 1'b0, "R8 expiry in new mode");
    clear_flags(); test_mode_i = 0; @(negedge clk_i); @(negedge clk_i);

    // R11: active-low pins
    act_low_i = 1; @(negedge clk_i);
    expect_pins(1'b0, 1'b0, 1'b0, 1'b0, "R11 active-low released");
    osc_bad_i = 1; @(negedge clk_i);
    expect_pins(1'b0, 1'b1, 1'b0, 1'b1, "R11 active-low pulling");
    expect_out(1'b1, 1'b1, "R12 fault mode");
    osc_bad_i = 0; @(negedge clk_i);
    act_low_i = 0; @(negedge clk_i);
    uv_dly_sel_i = 3'd0; uv_i = 1; @(negedge clk_i);
    pulse(BASE);
    expect_pins(1'b0, 1'b1, 1'b1, 1'b1, "R11 active-high driving");
    clear_flags(); @(negedge clk_i);

    // R9: latch holds until reset
    latch_en_i = 1;
    osc_bad_i = 1; @(negedge clk_i);
    osc_bad_i = 0;
    repeat (20) @(negedge clk_i);
    expect_out(1'b1, 1'b1, "R9 latched hold");
    ov_dly_sel_i = 3'd0; ov_i = 1; @(negedge clk_i);
    do_reset();
    expect_out(1'b0, 1'b0, "R9 reset clears");
    ov_i = 1; @(negedge clk_i);
    pulse(BASE);
    ov_i = 0; repeat (5) @(negedge clk_i);
    expect_out(1'b1, 1'b0, "R9 ov latched");
    latch_en_i = 0; do_reset();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule